// File: doc/BRIEF.md
# Eight-Slot TDM Serial Audio Port (Slave)

This block is the digital serial port for an eight-channel audio converter, working in both directions at once. The serial bit clock and the frame sync both arrive from an external master. The block never drives them. It oversamples both with its own system clock and finds their edges. A rising frame sync starts a frame of 256 bit periods. The frame is split into eight slots of 32 bits. In each slot the sample sits at the top, most significant bit first.

On the capture side, the block shifts eight samples out on a serial output. It latches them from a parallel input when the frame starts. On the playback side, it shifts eight samples in from a serial input. When the last slot has been taken in, it presents all eight at once, sign-extended, with a single-cycle strobe. A two-bit code selects the sample length. The block reads that code only at frame starts. A frame sync that comes too soon restarts the frame and raises a sticky error flag.

Top module: `tdm_serial_port`

## Requirements
- R1: While reset is high and after it is released, `sdout_o`, `rx_valid_o`, `frame_err_o` and `rx_samples_o` are all zero until the first frame starts.
- R2: A frame starts when a rising edge of `sclk_i` finds `fs_i` high after it was low at the previous rising edge. The next rising edge of `sclk_i` takes in bit 0, which is the MSB of slot 0. Later rising edges take in bits 1 to 255. Bit index i falls in slot i/32, at position i%32 within that slot.
- R3: At bit position p of slot s, `sdout_o` carries the latched transmit sample s, bit L-1-p, for p < L. For p >= L it carries 0. Apart from the frame-start bit, it changes only after a falling edge of `sclk_i`.
- R4: The MSB of slot 0 is driven right after the rising edge that detects the frame start. It is already valid before the falling edge that follows that rising edge.
- R5: For each slot, the first L serial input bits are taken as a sample, MSB first. The bits after them in the slot are ignored. The sample appears on `rx_samples_o` right-aligned and sign-extended to 24 bits.
- R6: The length code maps as 00 = 16, 01 = 18, 10 = 20 and 11 = 24 bits. `len_sel_i` is latched only when a frame starts. A change during a frame has no effect on that frame.
- R7: `tx_samples_i` is latched when a frame starts. A change during a frame has no effect on the bits sent in that frame.
- R8: When the rising edge that takes in bit 255 arrives, all eight received samples are updated together and `rx_valid_o` pulses high for one clock. Nothing is published before the first frame start.
- R9: If a frame start arrives at any bit count other than the end of a full frame, the block restarts the frame and discards the partial frame without a valid pulse. It then sets `frame_err_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | External serial bit clock, 256 periods per frame |
| fs_i | input | 1 | External frame sync; a rising edge marks a frame start |
| sdin_i | input | 1 | Serial playback data, sampled on rising bit-clock edges |
| sdout_o | output | 1 | Serial capture data, MSB first |
| len_sel_i | input | 2 | Sample length code (00=16, 01=18, 10=20, 11=24) |
| tx_samples_i | input | 192 | Eight right-aligned transmit samples, slot s in bits [24s+23:24s] |
| rx_samples_o | output | 192 | Eight received samples, slot s in bits [24s+23:24s], sign-extended |
| rx_valid_o | output | 1 | One-clock strobe when a complete frame is published |
| frame_err_o | output | 1 | Sticky flag for a frame start that arrived out of place |

## Verification
The bench runs full frames at all four length codes. The sample sets are built from seeds so that the slots carry mixed signs and bit patterns. The padding bits of the input are driven high, so a capture window that is too long, or a mis-set sign extension, shows up as wrong data. Because every bit is compared, an off-by-one in the frame alignment or in the slot boundaries also shows up. One frame changes the length code and the transmit samples halfway through, to show that both are latched. A frame sync that comes early checks the discard, the error flag and how the block recovers on the next frame. A probe taken before the first falling edge shows that the first MSB is driven early.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Sample length code, read at frame start
    typedef enum logic [1:0] {
        LEN_16 = 2'b00,
        LEN_18 = 2'b01,
        LEN_20 = 2'b10,
        LEN_24 = 2'b11
    } len_code_e;

    // Bit-clock events seen in the system clock domain
    typedef struct packed {
        logic rise;      // rising bit-clock edge this cycle
        logic fall;      // falling bit-clock edge this cycle
        logic fs_start;  // rising edge that sees a new frame sync
        logic data;      // serial input sampled with the bit clock
    } sclk_evt_t;

    function automatic int unsigned len_bits(input len_code_e code);
        case (code)
            LEN_16:  return 16;
            LEN_18:  return 18;
            LEN_20:  return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
    import tdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    input  logic      fs_i,
    input  logic      sdin_i,
    output sclk_evt_t evt_o
);

    logic sclk_q;
    logic sclk_q2;
    logic fs_q;
    logic fs_prev;
    logic sdin_q;
    logic rise_w;

    assign rise_w = sclk_q & ~sclk_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sclk_q2 <= 1'b0;
            fs_q    <= 1'b0;
            fs_prev <= 1'b0;
            sdin_q  <= 1'b0;
        end else begin
            sclk_q  <= sclk_i;
            sclk_q2 <= sclk_q;
            fs_q    <= fs_i;
            sdin_q  <= sdin_i;
            if (rise_w) begin
                fs_prev <= fs_q;
            end
        end
    end

    assign evt_o.rise     = rise_w;
    assign evt_o.fall     = ~sclk_q & sclk_q2;
    assign evt_o.fs_start = rise_w & fs_q & ~fs_prev;
    assign evt_o.data     = sdin_q;

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        evt_o.fs_start |-> evt_o.rise && !evt_o.fall) else $error("start off edge"); // R2

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  sclk_evt_t                                   evt_i,
    input  len_code_e                                   len_sel_i,
    output logic [$clog2(NUM_SLOTS*SLOT_BITS)-1:0]      cnt_o,
    output logic                                        locked_o,
    output len_code_e                                   len_o,
    output logic                                        frame_err_o
);

    localparam int CNT_W = $clog2(NUM_SLOTS * SLOT_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_SLOTS * SLOT_BITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;
    len_code_e        len_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
            len_q    <= LEN_16;
            err_q    <= 1'b0;
        end else if (evt_i.rise) begin
            if (evt_i.fs_start) begin
                cnt_q    <= '0;
                locked_q <= 1'b1;
                len_q    <= len_sel_i;
                if (locked_q && (cnt_q != CNT_LAST)) begin
                    err_q <= 1'b1;
                end
            end else if (locked_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o       = cnt_q;
    assign locked_o    = locked_q;
    assign len_o       = len_q;
    assign frame_err_o = err_q;

    AST_LEN_LATCHED: assert property (@(posedge clk) disable iff (rst)
        !evt_i.fs_start |=> $stable(len_q)) else $error("length moved mid-frame"); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q) else $error("error flag dropped"); // R9

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  sclk_evt_t                              evt_i,
    input  logic [$clog2(NUM_SLOTS*SLOT_BITS)-1:0] cnt_i,
    input  logic                                   locked_i,
    input  len_code_e                              len_q_i,
    input  len_code_e                              len_sel_i,
    input  logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]     tx_samples_i,
    output logic                                   sdout_o
);

    localparam int CNT_W   = $clog2(NUM_SLOTS * SLOT_BITS);
    localparam int POS_W   = $clog2(SLOT_BITS);
    localparam int SLOT_IW = $clog2(NUM_SLOTS);
    localparam int BI_W    = $clog2(SAMPLE_W);

    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] hold_q;
    logic                               sdout_q;

    // Bit for a frame index: left-justified sample, zero padding
    function automatic logic pick_bit(
        input logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] smp,
        input len_code_e                          code,
        input logic [CNT_W-1:0]                   idx
    );
        logic [SLOT_IW-1:0] slot;
        logic [POS_W-1:0]   pos;
        int unsigned        l;
        logic [BI_W-1:0]    bi;
        slot = idx[CNT_W-1:POS_W];
        pos  = idx[POS_W-1:0];
        l    = len_bits(code);
        bi   = BI_W'(l - 32'(pos) - 32'd1);
        if (32'(pos) < l) begin
            return smp[slot][bi];
        end
        return 1'b0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            sdout_q <= 1'b0;
        end else if (evt_i.fs_start) begin
            hold_q  <= tx_samples_i;
            sdout_q <= pick_bit(tx_samples_i, len_sel_i, '0);
        end else if (evt_i.fall && locked_i) begin
            sdout_q <= pick_bit(hold_q, len_q_i, cnt_i);
        end
    end

    assign sdout_o = sdout_q;

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(evt_i.rise || evt_i.fall) |=> $stable(sdout_q)) else $error("sdout moved off edge"); // R3
    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        !evt_i.fs_start |=> $stable(hold_q)) else $error("tx samples moved mid-frame"); // R7

endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  sclk_evt_t                              evt_i,
    input  logic [$clog2(NUM_SLOTS*SLOT_BITS)-1:0] cnt_i,
    input  logic                                   locked_i,
    input  len_code_e                              len_q_i,
    output logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]     rx_samples_o,
    output logic                                   rx_valid_o
);

    localparam int CNT_W   = $clog2(NUM_SLOTS * SLOT_BITS);
    localparam int POS_W   = $clog2(SLOT_BITS);
    localparam int SLOT_IW = $clog2(NUM_SLOTS);
    localparam int BI_W    = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_SLOTS * SLOT_BITS - 1);

    logic [SLOT_IW-1:0]                 slot_w;
    logic [POS_W-1:0]                   pos_w;
    int unsigned                        len_w;
    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] sext_w;
    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] rx_q;
    logic                               valid_q;

    assign slot_w = cnt_i[CNT_W-1:POS_W];
    assign pos_w  = cnt_i[POS_W-1:0];
    assign len_w  = len_bits(len_q_i);

    function automatic logic [SAMPLE_W-1:0] sign_ext(
        input logic [SAMPLE_W-1:0] v,
        input int unsigned         l
    );
        logic [SAMPLE_W-1:0] r;
        logic                sb;
        sb = v[BI_W'(l - 32'd1)];
        for (int b = 0; b < SAMPLE_W; b++) begin
            r[b] = (32'(b) < l) ? v[b] : sb;
        end
        return r;
    endfunction

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [SAMPLE_W-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (evt_i.rise && (slot_w == SLOT_IW'(s))) begin
                if (pos_w == '0) begin
                    acc_q <= SAMPLE_W'(evt_i.data);
                end else if (32'(pos_w) < len_w) begin
                    acc_q <= {acc_q[SAMPLE_W-2:0], evt_i.data};
                end
            end
        end
        assign sext_w[s] = sign_ext(acc_q, len_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (evt_i.rise && locked_i && (cnt_i == CNT_LAST)) begin
                rx_q    <= sext_w;
                valid_q <= 1'b1;
            end
        end
    end

    assign rx_samples_o = rx_q;
    assign rx_valid_o   = valid_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q) else $error("valid wider than one cycle"); // R8

endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sclk_i,
    input  logic                          fs_i,
    input  logic                          sdin_i,
    output logic                          sdout_o,
    input  logic [1:0]                    len_sel_i,
    input  logic [NUM_SLOTS*SAMPLE_W-1:0] tx_samples_i,
    output logic [NUM_SLOTS*SAMPLE_W-1:0] rx_samples_o,
    output logic                          rx_valid_o,
    output logic                          frame_err_o
);

    localparam int CNT_W = $clog2(NUM_SLOTS * SLOT_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_SLOTS * SLOT_BITS - 1);

    sclk_evt_t                          evt;
    logic [CNT_W-1:0]                   bit_cnt;
    logic                               locked;
    len_code_e                          len_q;
    len_code_e                          len_sel;
    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] tx_arr;
    logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] rx_arr;

    assign len_sel      = len_code_e'(len_sel_i);
    assign tx_arr       = tx_samples_i;
    assign rx_samples_o = rx_arr;

    tdm_edge_sync i_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fs_i   (fs_i),
        .sdin_i (sdin_i),
        .evt_o  (evt)
    );

    tdm_frame_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) i_frame (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .len_sel_i   (len_sel),
        .cnt_o       (bit_cnt),
        .locked_o    (locked),
        .len_o       (len_q),
        .frame_err_o (frame_err_o)
    );

    tdm_tx_serializer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W)) i_tx (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .cnt_i        (bit_cnt),
        .locked_i     (locked),
        .len_q_i      (len_q),
        .len_sel_i    (len_sel),
        .tx_samples_i (tx_arr),
        .sdout_o      (sdout_o)
    );

    tdm_rx_deserializer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W)) i_rx (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .cnt_i        (bit_cnt),
        .locked_i     (locked),
        .len_q_i      (len_q),
        .rx_samples_o (rx_arr),
        .rx_valid_o   (rx_valid_o)
    );

    AST_VALID_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(bit_cnt) == CNT_LAST) else $error("publish off frame end"); // R8
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |-> $stable(rx_samples_o)) else $error("rx data moved without strobe"); // R8
    AST_NO_PUBLISH_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> locked) else $error("publish before lock"); // R8

endmodule

// File: tb/test_tdm_serial_port.sv
module test_tdm_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         sclk;
    logic         fs;
    logic         sdin;
    logic         sdout;
    logic [1:0]   len_sel;
    logic [191:0] tx_samples;
    logic [191:0] rx_samples;
    logic         rx_valid;
    logic         frame_err;

    int nchk  = 0;
    int nfail = 0;
    int vcount = 0;
    logic [191:0] last_rx = '0;

    bit           pend = 1'b0;
    logic [191:0] pend_exp = '0;
    string        pend_tag = "R8";

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdm_serial_port i_tdm_serial_port (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .fs_i         (fs),
        .sdin_i       (sdin),
        .sdout_o      (sdout),
        .len_sel_i    (len_sel),
        .tx_samples_i (tx_samples),
        .rx_samples_o (rx_samples),
        .rx_valid_o   (rx_valid),
        .frame_err_o  (frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount  = vcount + 1;
            last_rx = rx_samples;
        end
    end

    // len code, tx seed, rx seed
    localparam int NVEC = 6;
    localparam logic [49:0] VEC [NVEC] = '{
        {2'b00, 24'h00A5C3, 24'h00F00F},
        {2'b01, 24'h02B1E7, 24'h03FFFF},
        {2'b10, 24'h0FFFFF, 24'h080000},
        {2'b11, 24'hFFFFFF, 24'h800000},
        {2'b11, 24'h5A5A5A, 24'h123456},
        {2'b00, 24'h000000, 24'h00FFFF}
    };

    function automatic int lenb(input logic [1:0] c);
        case (c)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] gen(input logic [23:0] seed, input int s);
        return (seed ^ 24'(s * 32'h0002D4B1)) + 24'(s * 32'h0000F00F);
    endfunction

    function automatic logic [191:0] pack_tx(input logic [23:0] seed);
        logic [191:0] r;
        for (int s = 0; s < 8; s++) r[s*24 +: 24] = gen(seed, s);
        return r;
    endfunction

    function automatic logic txbit(input logic [23:0] seed, input logic [1:0] c, input int idx);
        logic [23:0] g;
        int p;
        int l;
        g = gen(seed, idx / 32);
        p = idx % 32;
        l = lenb(c);
        return (p < l) ? g[l-1-p] : 1'b0;
    endfunction

    // padding driven high: must be ignored
    function automatic logic rxbit(input logic [23:0] seed, input logic [1:0] c, input int idx);
        logic [23:0] g;
        int p;
        int l;
        g = gen(seed, idx / 32);
        p = idx % 32;
        l = lenb(c);
        return (p < l) ? g[l-1-p] : 1'b1;
    endfunction

    function automatic logic [191:0] exp_rx(input logic [23:0] seed, input logic [1:0] c);
        logic [191:0] r;
        logic [23:0] g;
        int l;
        l = lenb(c);
        for (int s = 0; s < 8; s++) begin
            g = gen(seed, s);
            for (int b = 0; b < 24; b++) r[s*24 + b] = (b < l) ? g[b] : g[l-1];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] c, input logic [23:0] txs, input logic [23:0] rxs,
                             input int nper, input bit chg, input string tag);
        int txerr = 0;
        int vc0 = 0;
        len_sel    = c;
        tx_samples = pack_tx(txs);
        for (int p = 0; p < nper; p++) begin
            sclk = 1'b0;
            fs   = (p == 0);
            sdin = (p == 0) ? 1'b0 : rxbit(rxs, c, p - 1);
            if (chg && p == 128) begin
                len_sel    = ~c;
                tx_samples = ~tx_samples;
            end
            if (p == 0) vc0 = vcount;
            repeat (HALF_SCLK) @(negedge clk);
            if (p >= 1 && sdout !== txbit(txs, c, p - 1)) txerr = txerr + 1;
            sclk = 1'b1;
            repeat (HALF_SCLK) @(negedge clk);
            if (p == 0) begin
                chk("R4 early MSB", 192'(sdout), 192'(txbit(txs, c, 0)));
                if (pend) begin
                    chk({pend_tag, " valid count"}, 192'(vcount), 192'(vc0 + 1));
                    chk({pend_tag, " rx data"}, last_rx, pend_exp);
                end else begin
                    chk({pend_tag, " no publish"}, 192'(vcount), 192'(vc0));
                end
            end
        end
        if (nper == 256) chk({tag, " tx bit errors"}, 192'(txerr), 192'(0));
        pend     = (nper == 256);
        pend_exp = exp_rx(rxs, c);
        pend_tag = (nper == 256) ? "R5 R2" : "R9";
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail = nfail + 1;
        nchk  = nchk + 1;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; fs = 1'b0; sdin = 1'b0;
        len_sel = 2'b00; tx_samples = '0;
        repeat (5) @(negedge clk);
        chk("R1 sdout in reset", 192'(sdout), 192'(0));
        chk("R1 valid in reset", 192'(rx_valid), 192'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sdout", 192'(sdout), 192'(0));
        chk("R1 frame_err", 192'(frame_err), 192'(0));
        chk("R1 rx_samples", rx_samples, 192'(0));
        chk("R1 valid", 192'(vcount), 192'(0));

        // R3 R5 R6: table of lengths and patterns
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][49:48], VEC[v][47:24], VEC[v][23:0], 256, 1'b0, "R3 R6");
        end

        // R6 R7: length and tx samples changed mid-frame
        run_frame(2'b01, 24'h3C3C3C, 24'h6B2D11, 256, 1'b1, "R6 R7 mid-frame change");
        chk("R9 no error yet", 192'(frame_err), 192'(0));

        // R9: early frame sync
        run_frame(2'b10, 24'h111111, 24'h777777, 100, 1'b0, "R9 partial");
        run_frame(2'b11, 24'hABCDEF, 24'h987654, 256, 1'b0, "R9 recovered R3");
        chk("R9 frame_err set", 192'(frame_err), 192'(1));
        run_frame(2'b00, 24'h000000, 24'h000000, 1, 1'b0, "R8 flush");
        chk("R9 frame_err sticky", 192'(frame_err), 192'(1));

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule